// File: doc/BRIEF.md
# Load/Store Byte-Lane Formatter

This block sits between a 32-bit core's data memory port and its register write-back path. On a load it takes the aligned word returned by memory, the two low bits of the byte address and the access kind. It picks out the addressed byte or halfword and widens it to a full register value. Signed loads copy the sign bit into the upper bits. Unsigned loads fill the upper bits with zeros. Word loads pass through unchanged.

On a store it builds the byte-enable mask and the write word from the low bits of the source register. The data is copied into every lane, so whichever lane is enabled carries the correct bytes. Stores have no signed or unsigned forms. An access whose address is not a multiple of its size, or that uses the reserved size code, is not split into parts. Instead it raises an error flag and suppresses all byte enables.

The result is registered and appears exactly one clock after the request is presented. The memory itself and any trap handling are outside this block.

Top module: `ldst_lane_unit`

## Requirements
- R1: A signed byte load (`op_size`=0, `op_unsigned`=0) returns the byte at bits [8*`addr_lo`+7 : 8*`addr_lo`] of `mem_rdata` in bits [7:0], with bit 7 of that byte copied into bits [31:8].
- R2: An unsigned byte load (`op_size`=0, `op_unsigned`=1) returns the same selected byte with bits [31:8] zero.
- R3: A signed halfword load (`op_size`=1, `op_unsigned`=0) with `addr_lo`[0]=0 returns bits [16*`addr_lo`[1]+15 : 16*`addr_lo`[1]] of `mem_rdata` in bits [15:0], with bit 15 of that halfword copied into bits [31:16].
- R4: An unsigned halfword load (`op_size`=1, `op_unsigned`=1) with `addr_lo`[0]=0 returns the same halfword with bits [31:16] zero.
- R5: A word load (`op_size`=2) with `addr_lo`=0 returns `mem_rdata` unchanged, whatever the value of `op_unsigned`.
- R6: A byte store (`op_size`=0, `is_store`=1) drives `be` with only bit `addr_lo` set, and drives `wdata` with `src_data`[7:0] in all four byte lanes.
- R7: A halfword store with `addr_lo`[0]=0 drives `be`=4'b0011 when `addr_lo`[1]=0 and 4'b1100 when `addr_lo`[1]=1, and drives `wdata` with `src_data`[15:0] in both halfword lanes.
- R8: A word store with `addr_lo`=0 drives `be`=4'b1111 and `wdata`=`src_data`.
- R9: An access is misaligned if it is a halfword with `addr_lo`[0]=1, a word with `addr_lo`≠0, or uses `op_size`=3. A misaligned access sets `misalign`=1, `be`=0, `wdata`=0 and `ld_result`=0.
- R10: Every output is registered. The result of a request with `in_valid`=1 appears in the next cycle, together with `out_valid`=1. A cycle with `in_valid`=0, or a cycle in reset, gives `out_valid`=0 and all other outputs 0 in the following cycle.
- R11: A load drives `be`=0 and `wdata`=0. A store drives `ld_result`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present this cycle |
| is_store | input | 1 | 1 = store, 0 = load |
| op_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| op_unsigned | input | 1 | Zero-extend instead of sign-extend (loads only) |
| addr_lo | input | 2 | Low byte-address bits |
| mem_rdata | input | 32 | Aligned word read from memory |
| src_data | input | 32 | Store source register value |
| out_valid | output | 1 | Registered result valid |
| ld_result | output | 32 | Extended load value |
| be | output | 4 | Store byte enables, one per byte lane |
| wdata | output | 32 | Lane-replicated store data |
| misalign | output | 1 | Misaligned or reserved-size access |

## Verification
Every output is due exactly one rising edge after the request edge. The driver presents a request at a falling edge and pushes the expected outputs into a queue at the same moment. The monitor samples at the next falling edge, half a period after the capturing rising edge, and pops the oldest entry to compare against. An idle cycle is placed between bursts, and the bench checks that the following cycle shows zeros with the valid flag low.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
    localparam int XLEN    = 32;
    localparam int NLANES  = XLEN / 8;
    localparam int LO_W    = $clog2(NLANES);

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_RSVD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic              err;
        logic [NLANES-1:0] be;
        logic [XLEN-1:0]   wdata;
        logic [XLEN-1:0]   ldata;
    } lane_res_t;

    function automatic logic is_misaligned(acc_size_e sz, logic [LO_W-1:0] lo);
        case (sz)
            ACC_BYTE: return 1'b0;
            ACC_HALF: return lo[0];
            ACC_WORD: return |lo;
            default:  return 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/lsu_align_check.sv
module lsu_align_check
    import lsu_lane_pkg::*;
#(
    parameter int LW = LO_W
) (
    input  acc_size_e       size,
    input  logic [LW-1:0]   lo,
    output logic            err
);
    always_comb err = is_misaligned(size, lo);
endmodule

// File: rtl/lsu_load_extend.sv
module lsu_load_extend
    import lsu_lane_pkg::*;
#(
    parameter int DW = XLEN,
    localparam int LW = $clog2(DW / 8)
) (
    input  acc_size_e       size,
    input  logic            uns,
    input  logic [LW-1:0]   lo,
    input  logic [DW-1:0]   rdata,
    output logic [DW-1:0]   result
);
    logic [7:0]  sel_b;
    logic [15:0] sel_h;
    logic        fill_b, fill_h;

    always_comb begin
        sel_b  = rdata[{lo, 3'b000} +: 8];
        sel_h  = rdata[{lo[LW-1:1], 4'b0000} +: 16];
        fill_b = ~uns & sel_b[7];
        fill_h = ~uns & sel_h[15];
        case (size)
            ACC_BYTE: result = {{(DW-8){fill_b}}, sel_b};
            ACC_HALF: result = {{(DW-16){fill_h}}, sel_h};
            ACC_WORD: result = rdata;
            default:  result = '0;
        endcase
    end
endmodule

// File: rtl/lsu_store_format.sv
module lsu_store_format
    import lsu_lane_pkg::*;
#(
    parameter int DW = XLEN,
    localparam int NL = DW / 8,
    localparam int LW = $clog2(NL)
) (
    input  acc_size_e       size,
    input  logic [LW-1:0]   lo,
    input  logic [DW-1:0]   src,
    output logic [NL-1:0]   be,
    output logic [DW-1:0]   wdata
);
    for (genvar g = 0; g < NL; g++) begin : g_lane
        localparam logic [LW-1:0] LANE = LW'(g);
        always_comb begin
            case (size)
                ACC_BYTE: begin
                    wdata[g*8 +: 8] = src[7:0];
                    be[g]           = (lo == LANE);
                end
                ACC_HALF: begin
                    wdata[g*8 +: 8] = src[(g%2)*8 +: 8];
                    be[g]           = (lo[LW-1:1] == LANE[LW-1:1]);
                end
                ACC_WORD: begin
                    wdata[g*8 +: 8] = src[g*8 +: 8];
                    be[g]           = 1'b1;
                end
                default: begin
                    wdata[g*8 +: 8] = '0;
                    be[g]           = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/ldst_lane_unit.sv
module ldst_lane_unit
    import lsu_lane_pkg::*;
#(
    parameter int DW = XLEN,
    localparam int NL = DW / 8,
    localparam int LW = $clog2(NL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          is_store,
    input  logic [1:0]    op_size,
    input  logic          op_unsigned,
    input  logic [LW-1:0] addr_lo,
    input  logic [DW-1:0] mem_rdata,
    input  logic [DW-1:0] src_data,
    output logic          out_valid,
    output logic [DW-1:0] ld_result,
    output logic [NL-1:0] be,
    output logic [DW-1:0] wdata,
    output logic          misalign
);
    acc_size_e     size;
    logic          err_c;
    logic [DW-1:0] ld_c, wd_c;
    logic [NL-1:0] be_c;
    lane_res_t     nxt, cur;
    logic          vld_q;

    assign size = acc_size_e'(op_size);

    lsu_align_check #(.LW(LW)) u_chk (
        .size(size), .lo(addr_lo), .err(err_c)
    );

    lsu_load_extend #(.DW(DW)) u_ld (
        .size(size), .uns(op_unsigned), .lo(addr_lo),
        .rdata(mem_rdata), .result(ld_c)
    );

    lsu_store_format #(.DW(DW)) u_st (
        .size(size), .lo(addr_lo), .src(src_data),
        .be(be_c), .wdata(wd_c)
    );

    always_comb begin
        nxt       = '0;
        nxt.err   = err_c;
        if (!err_c) begin
            if (is_store) begin
                nxt.be    = be_c;
                nxt.wdata = wd_c;
            end else begin
                nxt.ldata = ld_c;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !in_valid) begin
            cur   <= '0;
            vld_q <= 1'b0;
        end else begin
            cur   <= nxt;
            vld_q <= 1'b1;
        end
    end

    assign out_valid = vld_q;
    assign ld_result = cur.ldata;
    assign be        = cur.be;
    assign wdata     = cur.wdata;
    assign misalign  = cur.err;

    AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid) else $error("latency");  // R10
    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && be == '0 && ld_result == '0)) else $error("idle");  // R10
    AST_ERR_NO_ENABLES: assert property (@(posedge clk) disable iff (rst)
        (out_valid && misalign) |-> (be == '0 && wdata == '0 && ld_result == '0)) else $error("err");  // R9
    AST_BYTE_STORE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_store && op_size == 2'd0) |=> ($countones(be) == 1)) else $error("sb");  // R6
    AST_WORD_STORE_ALL: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_store && op_size == 2'd2 && addr_lo == '0) |=> (be == '1 && wdata == $past(src_data))) else $error("sw");  // R8
    AST_LBU_ZERO_TOP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !is_store && op_unsigned && op_size == 2'd0) |=> (ld_result[DW-1:8] == '0)) else $error("lbu");  // R2
    AST_LB_SIGN_COPY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !is_store && !op_unsigned && op_size == 2'd0) |=> (ld_result[DW-1:8] == {(DW-8){ld_result[7]}})) else $error("lb");  // R1
    AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !is_store) |=> (be == '0 && wdata == '0)) else $error("ld");  // R11
endmodule

// File: tb/sim_ldst_lane_unit.sv
module sim_ldst_lane_unit;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic        err;
        logic [3:0]  be;
        logic [31:0] wd;
        logic [31:0] ld;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0, is_store = 1'b0, op_unsigned = 1'b0;
    logic [1:0]  op_size = 2'd0, addr_lo = 2'd0;
    logic [31:0] mem_rdata = '0, src_data = '0;
    logic        out_valid, misalign;
    logic [31:0] ld_result, wdata;
    logic [3:0]  be;

    int n_vec = 0, n_bad = 0;
    bit done = 0;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ldst_lane_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .is_store(is_store),
        .op_size(op_size), .op_unsigned(op_unsigned), .addr_lo(addr_lo),
        .mem_rdata(mem_rdata), .src_data(src_data), .out_valid(out_valid),
        .ld_result(ld_result), .be(be), .wdata(wdata), .misalign(misalign)
    );

    function automatic exp_t model(logic st, logic [1:0] sz, logic u,
                                   logic [1:0] lo, logic [31:0] rd,
                                   logic [31:0] sd, string req);
        exp_t e;
        logic [7:0]  b;
        logic [15:0] h;
        e.req = req; e.err = 0; e.be = 0; e.wd = 0; e.ld = 0;
        if (sz == 3 || (sz == 1 && lo[0]) || (sz == 2 && lo != 0)) begin
            e.err = 1;
            return e;
        end
        b = rd >> (8 * lo);
        h = rd >> (16 * lo[1]);
        if (st) begin
            if (sz == 0) begin e.be = 4'b0001 << lo; e.wd = {4{sd[7:0]}}; end
            else if (sz == 1) begin e.be = lo[1] ? 4'b1100 : 4'b0011; e.wd = {2{sd[15:0]}}; end
            else begin e.be = 4'hF; e.wd = sd; end
        end else begin
            if (sz == 0) e.ld = u ? {24'b0, b} : 32'($signed(b));
            else if (sz == 1) e.ld = u ? {16'b0, h} : 32'($signed(h));
            else e.ld = rd;
        end
        return e;
    endfunction

    task automatic apply(logic st, logic [1:0] sz, logic u, logic [1:0] lo,
                         logic [31:0] rd, logic [31:0] sd, string req);
        @(negedge clk);
        in_valid = 1; is_store = st; op_size = sz; op_unsigned = u;
        addr_lo = lo; mem_rdata = rd; src_data = sd;
        sb_q.push_back(model(st, sz, u, lo, rd, sd, req));
    endtask

    task automatic idle_check();
        @(negedge clk);
        in_valid = 0;
        @(negedge clk);
        @(negedge clk);
        n_vec++;
        if (out_valid !== 0 || ld_result !== 0 || be !== 0 || wdata !== 0 || misalign !== 0) begin
            n_bad++;
            $display("FAIL R10 idle: valid=%b ld=%h be=%b wd=%h err=%b exp all zero",
                     out_valid, ld_result, be, wdata, misalign);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid && !done) begin
            exp_t e;
            n_vec++;
            if (sb_q.size() == 0) begin
                n_bad++;
                $display("FAIL R10 unexpected out_valid: act=1 exp=0");
            end else begin
                e = sb_q.pop_front();
                if (misalign !== e.err || be !== e.be || wdata !== e.wd || ld_result !== e.ld) begin
                    n_bad++;
                    $display("FAIL %s: act err=%b be=%b wd=%h ld=%h exp err=%b be=%b wd=%h ld=%h",
                             e.req, misalign, be, wdata, ld_result, e.err, e.be, e.wd, e.ld);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_vec++;
        if (out_valid !== 0 || be !== 0 || ld_result !== 0 || misalign !== 0) begin
            n_bad++;
            $display("FAIL R10 reset: valid=%b be=%b ld=%h exp zeros", out_valid, be, ld_result);
        end
        rst = 0;
        // R1 signed byte, every lane
        for (int i = 0; i < 4; i++) apply(0, 0, 0, 2'(i), 32'h80F1_7F23, '0, "R1 lb");
        // R2 unsigned byte
        for (int i = 0; i < 4; i++) apply(0, 0, 1, 2'(i), 32'h80F1_7F23, '0, "R2 lbu");
        // R3/R4 halfwords
        apply(0, 1, 0, 2'd0, 32'h1234_9ABC, '0, "R3 lh lane0 neg");
        apply(0, 1, 0, 2'd2, 32'h1234_9ABC, '0, "R3 lh lane2 pos");
        apply(0, 1, 0, 2'd2, 32'hC001_0000, '0, "R3 lh lane2 neg");
        apply(0, 1, 1, 2'd0, 32'h1234_9ABC, '0, "R4 lhu lane0");
        apply(0, 1, 1, 2'd2, 32'hF00D_0001, '0, "R4 lhu lane2");
        // R5 word, flag ignored
        apply(0, 2, 0, 2'd0, 32'hDEAD_BEEF, '0, "R5 lw");
        apply(0, 2, 1, 2'd0, 32'h8000_0001, '0, "R5 lw unsigned flag");
        idle_check();
        // R6 byte stores, R7 halfword, R8 word, R11 load fields
        for (int i = 0; i < 4; i++) apply(1, 0, 0, 2'(i), 32'hFFFF_FFFF, 32'h1122_33A5, "R6 sb");
        apply(1, 1, 0, 2'd0, 32'hFFFF_FFFF, 32'h5566_8899, "R7 sh low");
        apply(1, 1, 1, 2'd2, '0, 32'h5566_8899, "R7 sh high");
        apply(1, 2, 0, 2'd0, 32'hFFFF_FFFF, 32'hCAFE_F00D, "R8 sw");
        apply(1, 2, 1, 2'd0, '0, 32'h0BAD_C0DE, "R11 sw no load data");
        // R9 misaligned and reserved size
        apply(0, 1, 0, 2'd1, 32'h1234_5678, '0, "R9 lh odd");
        apply(0, 1, 1, 2'd3, 32'h1234_5678, '0, "R9 lhu odd");
        apply(0, 2, 0, 2'd2, 32'h1234_5678, '0, "R9 lw lo2");
        apply(1, 1, 0, 2'd3, '0, 32'hAAAA_5555, "R9 sh odd");
        apply(1, 2, 0, 2'd1, '0, 32'hAAAA_5555, "R9 sw lo1");
        apply(1, 3, 0, 2'd0, '0, 32'hAAAA_5555, "R9 reserved store");
        apply(0, 3, 1, 2'd0, 32'h1234_5678, '0, "R9 reserved load");
        apply(0, 0, 0, 2'd1, 32'hFFFF_FFFF, '0, "R11 lb after error");
        idle_check();
        if (sb_q.size() != 0) begin
            n_vec++; n_bad++;
            $display("FAIL R10 pending results: act=%0d exp=0", sb_q.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule